// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block produces the single active-low reset that holds a small processor system in a known state. It has two sources. The first is a supply-good flag from an undervoltage comparator outside the block. The second is a watchdog that software services by toggling a strobe pin. While the supply flag is low, reset is held low. Once the supply recovers, reset stays low for a stretch interval, which is either a standard length or a long length. If the strobe shows no edge within the selected timeout, the watchdog raises a reset pulse of the same stretch length. It then starts timing again from zero.

The watchdog timeout is picked by two select pins. It can be a short internal period, a long internal period, or a much longer external period. A separate enable pin turns the watchdog off completely, which matches the case of an undriven strobe. All intervals are parameters counted in prescaler ticks, so a simulation can use scaled-down values. The supply flag and the strobe each pass through a two-flop synchroniser. The selects and the enable are treated as quasi-static control levels. The block has no data stream, so it has no valid/ready interface. Every pin is a plain control or status level.

Top module: `sup_reset_ctrl`

## Requirements
- R1: Reset output `sys_rst_n` goes low no later than three clock edges after `supply_ok` goes low, and stays low for as long as `supply_ok` is low.
- R2: With `rst_hold_long`=0, after `supply_ok` returns high, `sys_rst_n` stays low for `RST_STD_TICKS` ticks (one tick every `TICK_DIV` clocks) and then goes high.
- R3: With `rst_hold_long`=1, the hold after supply recovery lasts `RST_LONG_TICKS` ticks instead.
- R4: Either a rising or a falling edge on `wd_strobe` restarts the watchdog count, so a strobe toggled faster than the timeout never causes a reset.
- R5: When `wd_enable`=1 and no strobe edge arrives within the selected timeout, `sys_rst_n` is driven low.
- R6: A watchdog reset lasts the same stretch interval as a supply reset. The watchdog count restarts from zero when that pulse ends, so a silent strobe gives repeated pulses one timeout apart.
- R7: With `wd_enable`=0, the watchdog never drives reset, however long the strobe stays idle.
- R8: With `wd_src_ext`=0 and `wd_period_long`=1, the timeout is `WD_LONG_TICKS` ticks. With `wd_period_long`=0, it is `WD_SHORT_TICKS` ticks.
- R9: With `wd_src_ext`=1, the timeout is `WD_EXT_TICKS` ticks, whatever `wd_period_long` is.
- R10: Any change of the effective timeout selection restarts the watchdog count from zero.
- R11: Synchronous `rst_n`=0 clears all internal state and drives `sys_rst_n` low on the next clock edge. After `rst_n` is released, reset stays low until the supply has been seen good and the stretch has elapsed.
- R12: While `sys_rst_n` is low for any reason, the watchdog count is held at zero. After release, a full timeout must pass before the watchdog can fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| supply_ok | input | 1 | Supply above threshold (1) from the external comparator |
| rst_hold_long | input | 1 | 1 selects the long post-recovery stretch |
| wd_enable | input | 1 | 1 enables the watchdog; 0 stands for an undriven strobe |
| wd_strobe | input | 1 | Watchdog service strobe; any edge services |
| wd_src_ext | input | 1 | 1 selects the external long timeout |
| wd_period_long | input | 1 | Internal timeout choice: 1 long, 0 short |
| sys_rst_n | output | 1 | Active-low reset to the processor system |

## Verification
A wrong stretch counter or tick prescaler appears as a release edge of `sys_rst_n` that is early or late by one or more ticks. The per-clock model comparison catches this on the exact cycle of the mismatch. A watchdog count that is not cleared by a strobe edge, a select change or an active reset shows up as an extra falling edge of `sys_rst_n`. The timeout limits are set in the tens of ticks, so this happens within one timeout of the fault. A limit decoded for the wrong select moves the watchdog fall by a whole period difference, and the comparison sees this in the first silent window of each mode.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    WD_SHORT = 2'd0,
    WD_LONG  = 2'd1,
    WD_EXT   = 2'd2
  } wd_sel_e;

  function automatic wd_sel_e pick_sel(input logic ext, input logic lng);
    if (ext)      return WD_EXT;
    else if (lng) return WD_LONG;
    else          return WD_SHORT;
  endfunction
endpackage

// File: rtl/sup_tick_gen.sv
module sup_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter bit INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= INIT;
      q  <= INIT;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int SHORT_TICKS = 6,
  parameter int LONG_TICKS  = 16,
  parameter int EXT_TICKS   = 40
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    strobe_s,
  input  logic    wd_en,
  input  wd_sel_e sel,
  input  logic    hold,
  output logic    fire
);
  localparam int M1 = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
  localparam int MX = (M1 > EXT_TICKS) ? M1 : EXT_TICKS;
  localparam int CW = $clog2(MX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          strobe_q;
  wd_sel_e       sel_q;
  logic          edge_seen;
  logic          clear;

  always_comb begin
    unique case (sel)
      WD_LONG: last = CW'(LONG_TICKS - 1);
      WD_EXT:  last = CW'(EXT_TICKS - 1);
      default: last = CW'(SHORT_TICKS - 1);
    endcase
  end

  assign edge_seen = strobe_s ^ strobe_q;
  assign clear     = hold | ~wd_en | edge_seen | (sel != sel_q) | fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      strobe_q <= 1'b0;
      sel_q    <= WD_SHORT;
      fire     <= 1'b0;
    end else begin
      strobe_q <= strobe_s;
      sel_q    <= sel;
      fire     <= 1'b0;
      if (clear) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == last) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: a fire pulse only follows a cycle with the watchdog enabled
  p_fire_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(wd_en));
  // R12: no fire may follow a cycle in which reset was active
  p_no_fire_in_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !fire);
  // R4: a strobe edge blocks a fire on the next edge
  p_edge_blocks_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !fire);
endmodule

// File: rtl/sup_stretch.sv
module sup_stretch #(
  parameter int STD_TICKS  = 8,
  parameter int LONG_TICKS = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok_s,
  input  logic wd_fire,
  input  logic long_sel,
  output logic act
);
  localparam int MX = (STD_TICKS > LONG_TICKS) ? STD_TICKS : LONG_TICKS;
  localparam int SW = $clog2(MX + 1);

  logic [SW-1:0] cnt;
  logic [SW-1:0] last;

  assign last = long_sel ? SW'(LONG_TICKS - 1) : SW'(STD_TICKS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b1;
      cnt <= '0;
    end else if (!supply_ok_s || wd_fire) begin
      act <= 1'b1;
      cnt <= '0;
    end else if (act && tick) begin
      if (cnt == last) begin
        act <= 1'b0;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1: a low synchronised supply flag forces reset on the next edge
  p_supply_low_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_s |=> act);
  // R6: a watchdog fire forces reset on the next edge
  p_fire_asserts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> act);
  // R2: release only happens on a tick with the supply good
  p_release_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> ($past(tick) && $past(supply_ok_s)));
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int TICK_DIV       = 4,
  parameter int RST_STD_TICKS  = 8,
  parameter int RST_LONG_TICKS = 20,
  parameter int WD_SHORT_TICKS = 6,
  parameter int WD_LONG_TICKS  = 16,
  parameter int WD_EXT_TICKS   = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic rst_hold_long,
  input  logic wd_enable,
  input  logic wd_strobe,
  input  logic wd_src_ext,
  input  logic wd_period_long,
  output logic sys_rst_n
);
  logic    tick;
  logic    supply_s;
  logic    strobe_s;
  logic    wd_fire;
  logic    rst_act;
  wd_sel_e sel;

  assign sel = pick_sel(wd_src_ext, wd_period_long);

  sup_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  sup_sync2 #(.INIT(1'b0)) u_sync_supply (
    .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(supply_s)
  );

  sup_sync2 #(.INIT(1'b0)) u_sync_strobe (
    .clk(clk), .rst_n(rst_n), .d(wd_strobe), .q(strobe_s)
  );

  sup_wdog #(
    .SHORT_TICKS(WD_SHORT_TICKS),
    .LONG_TICKS (WD_LONG_TICKS),
    .EXT_TICKS  (WD_EXT_TICKS)
  ) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strobe_s(strobe_s),
    .wd_en(wd_enable), .sel(sel), .hold(rst_act), .fire(wd_fire)
  );

  sup_stretch #(
    .STD_TICKS (RST_STD_TICKS),
    .LONG_TICKS(RST_LONG_TICKS)
  ) u_stretch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok_s(supply_s),
    .wd_fire(wd_fire), .long_sel(rst_hold_long), .act(rst_act)
  );

  assign sys_rst_n = ~rst_act;

  // R11: system reset asserts the output on the next edge
  p_sysrst_asserts_r11: assert property (@(posedge clk)
    !rst_n |=> !sys_rst_n);
endmodule

// File: tb/tb_sup_reset_ctrl.sv
module tb_sup_reset_ctrl;
  localparam int DIV = 4, S_STD = 8, S_LNG = 20, W_S = 6, W_L = 16, W_E = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0, supply_ok = 1'b0, rst_hold_long = 1'b0, wd_enable = 1'b0;
  logic wd_strobe = 1'b0, wd_src_ext = 1'b0, wd_period_long = 1'b0;
  logic sys_rst_n;

  always #2.5 clk = ~clk;

  sup_reset_ctrl dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .rst_hold_long(rst_hold_long),
    .wd_enable(wd_enable), .wd_strobe(wd_strobe), .wd_src_ext(wd_src_ext),
    .wd_period_long(wd_period_long), .sys_rst_n(sys_rst_n)
  );

  int tests = 0, fails = 0, cyc = 0, falls = 0;
  bit chk_on = 0, done = 0;
  string cur_req = "R11";
  logic prev_out = 1'b0;

  // behavioural reference state
  int m_tc = 0, m_scnt = 0, m_wcnt = 0, m_psel = 0;
  bit m_p1 = 0, m_p2 = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_act = 1, m_fire = 0;

  function automatic int wd_lim(int s);
    return (s == 2) ? W_E : (s == 1) ? W_L : W_S;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_tc = 0; m_scnt = 0; m_wcnt = 0; m_psel = 0;
      m_p1 = 0; m_p2 = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_act = 1; m_fire = 0;
    end else begin
      bit tk, edg, clr, nfire, nact;
      int sel, nw, ns;
      tk  = (m_tc == DIV - 1);
      edg = m_s2 ^ m_s3;
      sel = wd_src_ext ? 2 : (wd_period_long ? 1 : 0);
      clr = m_act || !wd_enable || edg || (sel != m_psel) || m_fire;
      nfire = 0; nw = m_wcnt;
      if (clr) nw = 0;
      else if (tk) begin
        if (m_wcnt == wd_lim(sel) - 1) begin nw = 0; nfire = 1; end
        else nw = m_wcnt + 1;
      end
      nact = m_act; ns = m_scnt;
      if (!m_p2 || m_fire) begin nact = 1; ns = 0; end
      else if (m_act && tk) begin
        if (m_scnt == (rst_hold_long ? S_LNG : S_STD) - 1) begin nact = 0; ns = 0; end
        else ns = m_scnt + 1;
      end
      m_tc = tk ? 0 : m_tc + 1;
      m_wcnt = nw; m_fire = nfire; m_act = nact; m_scnt = ns; m_psel = sel;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = wd_strobe;
      m_p2 = m_p1; m_p1 = supply_ok;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model, plus fall counting
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk(sys_rst_n === !m_act, cur_req, sys_rst_n, !m_act);
      if (prev_out && !sys_rst_n) falls++;
      prev_out = sys_rst_n;
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000 && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic toggle_run(input int period, input int reps);
    for (int i = 0; i < reps; i++) begin
      cycles(period);
      wd_strobe = ~wd_strobe;
    end
  endtask

  task automatic wait_release();
    while (sys_rst_n !== 1'b1) @(negedge clk);
  endtask

  initial begin
    int f0, lowlen, gap;
    @(posedge clk);
    chk_on = 1;
    cycles(5);
    chk(sys_rst_n === 1'b0, "R11", sys_rst_n, 0);

    rst_n = 1; cur_req = "R1";
    cycles(10);
    chk(sys_rst_n === 1'b0, "R1", sys_rst_n, 0);

    supply_ok = 1; cur_req = "R2";
    cycles(20);
    chk(sys_rst_n === 1'b0, "R2", sys_rst_n, 0);
    cycles(30);
    chk(sys_rst_n === 1'b1, "R2", sys_rst_n, 1);

    supply_ok = 0; cur_req = "R1";
    cycles(3);
    chk(sys_rst_n === 1'b0, "R1", sys_rst_n, 0);
    rst_hold_long = 1; supply_ok = 1; cur_req = "R3";
    cycles(60);
    chk(sys_rst_n === 1'b0, "R3", sys_rst_n, 0);
    cycles(40);
    chk(sys_rst_n === 1'b1, "R3", sys_rst_n, 1);
    rst_hold_long = 0;

    wd_enable = 1; cur_req = "R4"; f0 = falls;
    toggle_run(10, 20);
    chk(falls == f0, "R4", falls - f0, 0);

    cur_req = "R5";
    cycles(40);
    chk(falls == f0 + 1, "R5", falls - f0, 1);

    cur_req = "R6";
    while (sys_rst_n !== 1'b1) @(negedge clk);
    while (sys_rst_n !== 1'b0) @(negedge clk);
    lowlen = 0;
    while (sys_rst_n !== 1'b1) begin lowlen++; @(negedge clk); end
    chk(lowlen >= S_STD * DIV - DIV + 1 && lowlen <= S_STD * DIV + 1, "R6", lowlen, S_STD * DIV);
    gap = 0;
    while (sys_rst_n !== 1'b0) begin gap++; @(negedge clk); end
    chk(gap >= W_S * DIV - DIV && gap <= W_S * DIV + 4, "R6", gap, W_S * DIV);

    wd_enable = 0; cur_req = "R7";
    cycles(60); f0 = falls;
    cycles(300);
    chk(falls == f0, "R7", falls - f0, 0);

    wd_enable = 1; wd_period_long = 1; cur_req = "R8"; f0 = falls;
    toggle_run(40, 10);
    chk(falls == f0, "R8", falls - f0, 0);
    cycles(100);
    chk(falls > f0, "R8", falls - f0, 1);

    wait_release(); cycles(5);
    wd_src_ext = 1; wd_period_long = 0; cur_req = "R9";
    wait_release(); f0 = falls;
    toggle_run(120, 4);
    chk(falls == f0, "R9", falls - f0, 0);
    cycles(200);
    chk(falls > f0, "R9", falls - f0, 1);

    wd_src_ext = 0; cur_req = "R10";
    cycles(40); wait_release(); f0 = falls;
    for (int i = 0; i < 16; i++) begin
      cycles(18);
      wd_period_long = ~wd_period_long;
    end
    chk(falls == f0, "R10", falls - f0, 0);
    wd_period_long = 0;

    cur_req = "R12";
    wait_release();
    supply_ok = 0;
    cycles(100);
    supply_ok = 1;
    wait_release(); f0 = falls;
    cycles(15);
    chk(falls == f0, "R12", falls - f0, 0);

    cur_req = "R11";
    wait_release();
    rst_n = 0;
    cycles(1);
    chk(sys_rst_n === 1'b0, "R11", sys_rst_n, 0);
    rst_n = 1;
    cycles(20);
    chk(sys_rst_n === 1'b0, "R11", sys_rst_n, 0);
    cycles(40);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule